// File: doc/BRIEF.md
# Start-of-Frame Byte Delimiter Generator

This block sits behind a Manchester decoder. It watches the decoded NRZ receive stream, which arrives one bit per bit-clock enable at 10 Mb/s. It hunts for the end of the preamble and the start-of-frame delimiter. Once it finds them, it produces a byte-framing strobe. Every rising edge of that strobe marks the first bit of a received byte, beginning with the first bit of the destination address. External address-filtering logic can then collect whole bytes from the forwarded serial data and the forwarded bit clock.

The block also merges an external reject input with the result of the internal address filter. The result is a single reject decision that stays latched for the rest of the frame. When the frame is transmitted, when receive activity ends, or when the feature bit is cleared, the strobe drops. The delimiter hunt then starts again for the next frame.

Top module: `sfd_delim_gen`

## Requirements
- R1: The delimiter is found when the last eight received bits, in arrival order, are 1,0,1,0,1,0,1,1. Any number of alternating 1/0 preamble bits may come first. No strobe edge appears before that match.
- R2: The first rising edge of `byte_strobe` appears in the same clock cycle in which `ser_data` first shows the bit that follows the final delimiter bit. Both outputs update one clock after that bit's `bit_en` cycle.
- R3: After the delimiter, `byte_strobe` is high for 4 bit times and low for 4 bit times, repeating. It rises with bits 0, 8, 16, … after the delimiter.
- R4: All strobe periods count `bit_en` pulses and not clock cycles. The strobe pattern therefore does not depend on how many idle clocks separate the bits.
- R5: In the clock after any cycle with `tx_active` high, `byte_strobe` is low. The current frame is abandoned, and no strobe appears again until a new delimiter is found.
- R6: While a frame is active, a high level on `ext_reject` or on `int_reject` sets `frame_reject` one clock later. `frame_reject` then stays high until the frame ends.
- R7: When no frame is active (idle, or during the preamble hunt), `ext_reject` and `int_reject` have no effect, and `frame_reject` stays low.
- R8: A `bit_en` cycle that arrives while `feat_en` and `rx_active` are high and `tx_active` is low has two results one clock later: `ser_data` equals the bit received in that cycle, and `ser_clk` is high for exactly that one clock. At all other times `ser_clk` is low.
- R9: In the clock after any cycle with `feat_en` low, all four outputs are 0.
- R10: When `rx_active` falls, `byte_strobe` and `frame_reject` are 0 one clock later. The next frame needs a fresh delimiter.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle bit-clock enable; `rx_bit` is valid in this cycle |
| rx_bit | input | 1 | Decoded NRZ receive bit |
| rx_active | input | 1 | Receive activity; low ends the frame |
| tx_active | input | 1 | Transmit activity; forces the strobe low |
| feat_en | input | 1 | Feature enable; low holds all outputs idle |
| int_reject | input | 1 | Internal address-filter reject result |
| ext_reject | input | 1 | External reject request |
| byte_strobe | output | 1 | Byte-framing square wave, rising at each byte's first bit |
| ser_data | output | 1 | Forwarded serial data |
| ser_clk | output | 1 | Forwarded bit clock, one-cycle pulse per forwarded bit |
| frame_reject | output | 1 | Latched OR of external and internal reject for the current frame |

## Verification
The bench builds the block with its default parameters: eight bits per byte and the eight-bit delimiter 10101011. With these values a four-bit-high, four-bit-low strobe is fully observable across several bytes of random payload. Each bit is followed by a random gap of zero to three idle clocks, which exposes any counting of clocks where bit enables should be counted. Frames use random preamble lengths and random reject pulses placed inside the payload. Directed cases cover a transmit abort in mid-frame, reject pulses while idle and while hunting, and a whole frame sent with the feature disabled.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int          SFD_LEN_DEF     = 8;
    localparam logic [7:0]  SFD_PATTERN_DEF = 8'b1010_1011;
    localparam int          BYTE_BITS_DEF   = 8;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_HUNT  = 2'd1,
        FS_FRAME = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic data;
        logic clk;
    } fwd_t;

    // Leading half of a byte period: strobe is high while the bit index is below half.
    function automatic logic lead_half(input int unsigned idx, input int unsigned half);
        return idx < half;
    endfunction

endpackage

// File: rtl/sfd_matcher.sv
module sfd_matcher #(
    parameter int               LEN     = 8,
    parameter logic [LEN-1:0]   PATTERN = 8'b1010_1011
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  logic clr,
    input  logic din,
    output logic hit
);
    logic [LEN-1:0] hist_q;
    logic [LEN-1:0] cand;

    // Oldest bit at the MSB; candidate includes the incoming bit.
    assign cand = {hist_q[LEN-2:0], din};
    assign hit  = (cand == PATTERN);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= cand;
        end
    end

    // R1
    clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hist_q == '0));

endmodule

// File: rtl/sfd_strobe_gen.sv
module sfd_strobe_gen
    import sfd_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic keep,
    input  logic bit_en,
    output logic strobe
);
    localparam int CNT_W = (BYTE_BITS > 2) ? $clog2(BYTE_BITS) : 1;
    localparam int HALF  = BYTE_BITS / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             strobe_q;

    always_ff @(posedge clk) begin
        if (rst || !keep) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else if (run && bit_en) begin
            strobe_q <= lead_half(int'(cnt_q), HALF);
            cnt_q    <= (int'(cnt_q) == BYTE_BITS - 1) ? '0 : cnt_q + 1'b1;
        end
    end

    assign strobe = strobe_q;

    // R4
    strobe_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (keep && !bit_en) |=> $stable(strobe_q));

    // R3
    strobe_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !keep |=> !strobe_q);

endmodule

// File: rtl/sfd_reject_merge.sv
module sfd_reject_merge (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic keep,
    input  logic ext_rej,
    input  logic int_rej,
    output logic reject
);
    logic rej_q;

    always_ff @(posedge clk) begin
        if (rst || !keep) begin
            rej_q <= 1'b0;
        end else if (run) begin
            rej_q <= rej_q | ext_rej | int_rej;
        end
    end

    assign reject = rej_q;

    // R6
    reject_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rej_q && keep) |=> rej_q);

    // R7
    reject_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (!rej_q && !run) |=> !rej_q);

endmodule

// File: rtl/sfd_forward.sv
module sfd_forward
    import sfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fwd_ok,
    input  logic bit_en,
    input  logic din,
    output fwd_t fwd
);
    fwd_t fwd_q;

    always_ff @(posedge clk) begin
        if (rst || !fwd_ok) begin
            fwd_q <= '0;
        end else begin
            fwd_q.clk <= bit_en;
            if (bit_en) begin
                fwd_q.data <= din;
            end
        end
    end

    assign fwd = fwd_q;

    // R8
    forward_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_ok && bit_en) |=> (fwd_q.clk && (fwd_q.data == $past(din))));

endmodule

// File: rtl/sfd_delim_gen.sv
module sfd_delim_gen
    import sfd_pkg::*;
#(
    parameter int                   BYTE_BITS   = BYTE_BITS_DEF,
    parameter int                   SFD_LEN     = SFD_LEN_DEF,
    parameter logic [SFD_LEN-1:0]   SFD_PATTERN = SFD_PATTERN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic rx_active,
    input  logic tx_active,
    input  logic feat_en,
    input  logic int_reject,
    input  logic ext_reject,
    output logic byte_strobe,
    output logic ser_data,
    output logic ser_clk,
    output logic frame_reject
);
    frame_state_e state_q, state_d;
    logic         sfd_hit;
    logic         hunting, in_frame, keep_frame;
    logic         fwd_ok;
    fwd_t         fwd;

    assign hunting    = (state_q == FS_HUNT);
    assign in_frame   = (state_q == FS_FRAME);
    assign keep_frame = (state_d == FS_FRAME);
    assign fwd_ok     = feat_en && rx_active && !tx_active;

    always_comb begin
        state_d = state_q;
        if (!feat_en || !rx_active || tx_active) begin
            state_d = FS_IDLE;
        end else begin
            unique case (state_q)
                FS_IDLE:  state_d = FS_HUNT;
                FS_HUNT:  if (bit_en && sfd_hit) state_d = FS_FRAME;
                FS_FRAME: state_d = FS_FRAME;
                default:  state_d = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    sfd_matcher #(
        .LEN     (SFD_LEN),
        .PATTERN (SFD_PATTERN)
    ) u_match (
        .clk   (clk),
        .rst   (rst),
        .shift (hunting && bit_en),
        .clr   (!hunting),
        .din   (rx_bit),
        .hit   (sfd_hit)
    );

    sfd_strobe_gen #(
        .BYTE_BITS (BYTE_BITS)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .run    (in_frame),
        .keep   (keep_frame),
        .bit_en (bit_en),
        .strobe (byte_strobe)
    );

    sfd_reject_merge u_reject (
        .clk     (clk),
        .rst     (rst),
        .run     (in_frame),
        .keep    (keep_frame),
        .ext_rej (ext_reject),
        .int_rej (int_reject),
        .reject  (frame_reject)
    );

    sfd_forward u_fwd (
        .clk    (clk),
        .rst    (rst),
        .fwd_ok (fwd_ok),
        .bit_en (bit_en),
        .din    (rx_bit),
        .fwd    (fwd)
    );

    assign ser_data = fwd.data;
    assign ser_clk  = fwd.clk;

    // R1
    sfd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> $past(bit_en));

    // R2
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_strobe) |-> ($past(bit_en) && ser_clk));

    // R5
    tx_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        tx_active |=> !byte_strobe);

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !feat_en |=> (!byte_strobe && !ser_data && !ser_clk && !frame_reject));

    // R10
    rx_end_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_active |=> (!byte_strobe && !frame_reject));

endmodule

// File: tb/sfd_delim_gen_test.sv
module sfd_delim_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, rx_bit = 1'b0, rx_active = 1'b0, tx_active = 1'b0;
    logic feat_en = 1'b1, int_reject = 1'b0, ext_reject = 1'b0;
    logic byte_strobe, ser_data, ser_clk, frame_reject;

    int checks = 0;
    int fails  = 0;
    bit exp_rej  = 1'b0;
    bit rej_live = 1'b0;
    bit fwd_exp  = 1'b1;

    always #4 clk = ~clk;

    sfd_delim_gen uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .rx_active(rx_active), .tx_active(tx_active), .feat_en(feat_en),
        .int_reject(int_reject), .ext_reject(ext_reject),
        .byte_strobe(byte_strobe), .ser_data(ser_data), .ser_clk(ser_clk),
        .frame_reject(frame_reject)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_strobe(input int idx);
        return (idx % 8) < 4;
    endfunction

    // Send one bit, check outputs one clock later, then a random idle gap.
    task automatic send_bit(input bit b, input bit strb, input bit inj, input bit use_int);
        int gap;
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        chk(ser_clk == fwd_exp, "R8 ser_clk", ser_clk, fwd_exp);
        chk(ser_data == (fwd_exp & b), "R8 ser_data", ser_data, fwd_exp & b);
        chk(byte_strobe == strb, "R3 byte_strobe", byte_strobe, strb);
        chk(frame_reject == exp_rej, "R6 frame_reject", frame_reject, exp_rej);
        gap = $urandom_range(0, 3);
        if (inj && gap == 0) gap = 1;
        for (int g = 0; g < gap; g++) begin
            if (g == 0 && inj) begin
                if (use_int) int_reject = 1'b1; else ext_reject = 1'b1;
            end
            @(negedge clk);
            int_reject = 1'b0;
            ext_reject = 1'b0;
            if (g == 0 && inj && rej_live) exp_rej = 1'b1;
        end
        if (gap > 0) begin
            chk(ser_clk == 1'b0, "R4 ser_clk gap", ser_clk, 0);
            chk(frame_reject == exp_rej, "R6 R7 reject after gap", frame_reject, exp_rej);
        end
    endtask

    task automatic start_frame(input int npre, input bit inj_pre);
        bit [7:0] sfd = 8'b1010_1011;
        rx_active = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < npre; i++)
            send_bit((i % 2) == 0, 1'b0, inj_pre && (i == 1), 1'b0); // R7 during hunt
        for (int i = 7; i >= 0; i--)
            send_bit(sfd[i], 1'b0, 1'b0, 1'b0);                       // R1 no early edge
        rej_live = feat_en;
    endtask

    task automatic payload(input int nbits, input bit strb_en, input int inj_at,
                           input bit use_int, input bit zeros);
        for (int i = 0; i < nbits; i++)
            send_bit(zeros ? 1'b0 : 1'($urandom), strb_en && exp_strobe(i),
                     i == inj_at, use_int);                           // R2 R3 R4
    endtask

    task automatic end_frame();
        rx_active = 1'b0;
        rej_live  = 1'b0;
        @(negedge clk);
        exp_rej = 1'b0;
        chk(byte_strobe == 1'b0, "R10 strobe at end", byte_strobe, 0);
        chk(frame_reject == 1'b0, "R10 reject at end", frame_reject, 0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk({byte_strobe, ser_data, ser_clk, frame_reject} == 4'b0, "R11 reset outputs",
            {byte_strobe, ser_data, ser_clk, frame_reject}, 0);

        // R7: reject pulse while idle
        ext_reject = 1'b1;
        @(negedge clk);
        ext_reject = 1'b0;
        int_reject = 1'b1;
        @(negedge clk);
        int_reject = 1'b0;
        chk(frame_reject == 1'b0, "R7 idle reject ignored", frame_reject, 0);

        // Random frames
        for (int f = 0; f < 8; f++) begin
            int nb = $urandom_range(2, 6);
            int inj = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, nb * 8 - 1));
            fwd_exp = 1'b1;
            start_frame(2 * $urandom_range(1, 20), 1'b1);
            payload(nb * 8, 1'b1, inj, 1'($urandom), 1'b0);
            end_frame();
        end

        // R5: transmit abort mid-frame
        start_frame(16, 1'b0);
        payload(12, 1'b1, -1, 1'b0, 1'b0);
        tx_active = 1'b1;
        rej_live  = 1'b0;
        fwd_exp   = 1'b0;
        @(negedge clk);
        chk(byte_strobe == 1'b0, "R5 strobe low on tx", byte_strobe, 0);
        payload(8, 1'b0, -1, 1'b0, 1'b1);
        tx_active = 1'b0;
        fwd_exp   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        payload(16, 1'b0, -1, 1'b0, 1'b1);      // R5 no strobe without new delimiter
        end_frame();

        // R9: feature disabled for a whole frame
        feat_en = 1'b0;
        fwd_exp = 1'b0;
        @(negedge clk);
        start_frame(10, 1'b0);
        payload(16, 1'b0, 3, 1'b0, 1'b0);
        chk({byte_strobe, ser_data, ser_clk, frame_reject} == 4'b0, "R9 disabled outputs",
            {byte_strobe, ser_data, ser_clk, frame_reject}, 0);
        end_frame();
        feat_en = 1'b1;
        fwd_exp = 1'b1;
        @(negedge clk);

        // R1 R2: shortest preamble, frame works again after re-enable
        start_frame(0, 1'b0);
        payload(16, 1'b1, 5, 1'b1, 1'b0);
        end_frame();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule